// File: doc/BRIEF.md
# Quadrature Phase Counter

This block counts pulses from two external phase inputs, A and B, into a 16-bit up/down count register. A 4-bit mode field picks how the two inputs are read: full 4x quadrature decoding (every edge of either input counts, direction from phase order), pulse-and-direction (rising edges of A count, the level of B gives the direction), or 2x decoding on B (both edges of B count, A only sets the direction). Two other mode codes are kept but unsupported, and in them the count holds its value.

Both inputs are taken into the system clock domain through a two-flop synchroniser, and edges are found by comparing each synchronised sample with the one before it. A ceiling register bounds the count. Counting up from the ceiling clears the count to zero, and counting down from zero reloads the ceiling. A status bit records whether the last accepted count went up or down. Software reaches the count, ceiling, control and status through a small word-wide register port with a combinational read.

Top module: `qpc_counter`

## Requirements
- R1: After reset the count reads 0x0000, the ceiling 0xFFFF, the control register 0x0004 (mode 4, counting disabled) and the status register 0x0000.
- R2: Register addresses: 0 is the count (read/write), 1 the ceiling (read/write), 2 control (mode in bits 3:0, enable in bit 8, other bits read 0), 3 status (read-only). Writes to address 3 have no effect.
- R3: A phase input change applied before clock edge k reaches the count on edge k+2. The count does not move after edges k or k+1.
- R4: In mode 4, a single-input change counts one step. With pin pairs written as (A,B), the order 00→10→11→01→00 counts up and the reverse order counts down.
- R5: In mode 4, a change in both A and B between two consecutive synchronised samples leaves the count unchanged.
- R6: In mode 5, a rising edge of A counts up when B is 1 and down when B is 0. Falling edges of A and any change of B do not count.
- R7: In mode 7, each edge of B counts one step: up when A equals the new B level, down otherwise. Changes of A do not count.
- R8: In mode 6, mode 9 and any other code apart from 4, 5 and 7, the count holds its value.
- R9: Status bit 7 reads 1 after an upward count and 0 after a downward one. All other status bits read 0.
- R10: An upward count from a value equal to the ceiling gives 0x0000.
- R11: A downward count from 0x0000 gives the ceiling value.
- R12: A software write to the count wins over a count step in the same cycle.
- R13: With enable at 0 the count holds its value. Input changes seen while disabled cause no count when enable is set again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phase_a | input | 1 | External phase input A, asynchronous |
| phase_b | input | 1 | External phase input B, asynchronous |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data for reg_addr, combinational |

## Verification
The properties assume the phase inputs are slow relative to the clock: each level is held for at least one cycle, so no more than one accepted step can land in any cycle and every count move is one of hold, ±1, clear or ceiling reload. The properties also assume a count write is a single-cycle strobe on address 0. The stimulus changes A and B only at falling clock edges and holds each level for three cycles, which covers the whole synchroniser and step path. It drives a simultaneous change of both inputs only in the case that checks invalid steps are rejected.

// File: rtl/qpc_pkg.sv
// Package: shared constants for the quadrature phase counter.
// Assumes a control register at least nine bits wide.
package qpc_pkg;
    localparam int MODE_W       = 4;
    localparam int EN_BIT       = 8;
    localparam int STAT_DIR_BIT = 7;

    localparam logic [MODE_W-1:0] MODE_X4    = 4'd4;
    localparam logic [MODE_W-1:0] MODE_PDIR  = 4'd5;
    localparam logic [MODE_W-1:0] MODE_X2B   = 4'd7;
    localparam logic [MODE_W-1:0] MODE_RESET = MODE_X4;

    typedef enum logic [1:0] {
        ADDR_COUNT = 2'd0,
        ADDR_CEIL  = 2'd1,
        ADDR_CTRL  = 2'd2,
        ADDR_STAT  = 2'd3
    } qpc_addr_e;
endpackage

// File: rtl/qpc_sync.sv
// Module: qpc_sync
// Purpose: multi-stage synchroniser for a bundle of asynchronous inputs.
// Assumes each input bit is an independent slow level (no bus coherency).
module qpc_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    // Shift the raw inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/qpc_step_decode.sv
// Module: qpc_step_decode
// Purpose: turns synchronised A/B samples into a count step and direction
// according to the selected mode. Assumes at most one input edge per
// cycle except where an invalid 4x step must be rejected.
module qpc_step_decode
    import qpc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_s,
    input  logic              b_s,
    input  logic [MODE_W-1:0] mode,
    output logic              step,
    output logic              up
);
    logic a_p, b_p;
    logic a_chg, b_chg;

    // Hold the previous synchronised sample of each input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_p <= 1'b0;
            b_p <= 1'b0;
        end else begin
            a_p <= a_s;
            b_p <= b_s;
        end
    end

    assign a_chg = a_s ^ a_p;
    assign b_chg = b_s ^ b_p;

    // Map the edge pattern to a step and direction per mode.
    always_comb begin
        step = 1'b0;
        up   = 1'b0;
        case (mode)
            MODE_X4: begin
                step = a_chg ^ b_chg;
                up   = a_s ^ b_p;
            end
            MODE_PDIR: begin
                step = a_s & ~a_p;
                up   = b_s;
            end
            MODE_X2B: begin
                step = b_chg;
                up   = ~(a_s ^ b_s);
            end
            default: begin
                step = 1'b0;
                up   = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/qpc_count_core.sv
// Module: qpc_count_core
// Purpose: the count, ceiling and direction registers. Up from the ceiling
// clears, down from zero reloads the ceiling, a software count write wins.
// Assumes step is a single-cycle pulse.
module qpc_count_core #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          step,
    input  logic          up,
    input  logic          cnt_wr,
    input  logic [CW-1:0] cnt_wdata,
    input  logic          ceil_wr,
    input  logic [CW-1:0] ceil_wdata,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] ceil,
    output logic          dir_up
);
    logic [CW-1:0] cnt_nxt;
    logic          take;

    assign take = en & step;

    // Next count for an accepted step, including clear and reload.
    always_comb begin
        if (up) cnt_nxt = (cnt == ceil) ? '0 : cnt + CW'(1);
        else    cnt_nxt = (cnt == '0) ? ceil : cnt - CW'(1);
    end

    // Update count, ceiling and direction flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            ceil   <= '1;
            dir_up <= 1'b0;
        end else begin
            if (ceil_wr) ceil <= ceil_wdata;
            if (take)    dir_up <= up;
            if (cnt_wr)    cnt <= cnt_wdata;
            else if (take) cnt <= cnt_nxt;
        end
    end
endmodule

// File: rtl/qpc_counter.sv
// Module: qpc_counter (top)
// Purpose: quadrature / pulse-direction / 2x counter with a register port.
// Assumes CW >= 9 so the control fields fit, and phase inputs slower
// than the clock.
module qpc_counter
    import qpc_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          phase_a,
    input  logic          phase_b,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [CW-1:0] reg_wdata,
    output logic [CW-1:0] reg_rdata
);
    logic [1:0]        ab_s;
    logic              step, up;
    logic [MODE_W-1:0] mode_q;
    logic              en_q;
    logic              cnt_wr, ceil_wr, ctrl_wr;
    logic [CW-1:0]     cnt_q, ceil_q;
    logic              dir_up;

    qpc_sync #(.WIDTH(2), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({phase_b, phase_a}),
        .q     (ab_s)
    );

    qpc_step_decode u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .a_s   (ab_s[0]),
        .b_s   (ab_s[1]),
        .mode  (mode_q),
        .step  (step),
        .up    (up)
    );

    // Decode write strobes per register.
    always_comb begin
        cnt_wr  = reg_wr && (reg_addr == ADDR_COUNT);
        ceil_wr = reg_wr && (reg_addr == ADDR_CEIL);
        ctrl_wr = reg_wr && (reg_addr == ADDR_CTRL);
    end

    // Control register: mode and enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_RESET;
            en_q   <= 1'b0;
        end else if (ctrl_wr) begin
            mode_q <= reg_wdata[MODE_W-1:0];
            en_q   <= reg_wdata[EN_BIT];
        end
    end

    qpc_count_core #(.CW(CW)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en_q),
        .step       (step),
        .up         (up),
        .cnt_wr     (cnt_wr),
        .cnt_wdata  (reg_wdata),
        .ceil_wr    (ceil_wr),
        .ceil_wdata (reg_wdata),
        .cnt        (cnt_q),
        .ceil       (ceil_q),
        .dir_up     (dir_up)
    );

    // Read multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_COUNT: reg_rdata = cnt_q;
            ADDR_CEIL:  reg_rdata = ceil_q;
            ADDR_CTRL: begin
                reg_rdata[MODE_W-1:0] = mode_q;
                reg_rdata[EN_BIT]     = en_q;
            end
            default:    reg_rdata[STAT_DIR_BIT] = dir_up;
        endcase
    end
endmodule

// File: rtl/qpc_counter_chk.sv
// Module: qpc_counter_chk
// Purpose: temporal properties of the counter, bound into qpc_counter.
// Assumes at most one accepted step per cycle (slow phase inputs).
module qpc_counter_chk #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] cnt,
    input logic [CW-1:0] ceil,
    input logic [3:0]    mode,
    input logic          en,
    input logic          cnt_wr,
    input logic [CW-1:0] cnt_wdata
);
    // R1: defaults visible on the first edge out of reset.
    p_reset_defaults_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cnt == '0 && ceil == '1 && mode == 4'd4 && !en));

    // R12: a count write lands regardless of any step.
    p_write_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt == $past(cnt_wdata)));

    // R13: disabled counter holds.
    p_hold_disabled_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !cnt_wr) |=> (cnt == $past(cnt)));

    // R8: unsupported modes hold.
    p_unsup_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!(mode == 4'd4 || mode == 4'd5 || mode == 4'd7) && !cnt_wr)
        |=> (cnt == $past(cnt)));

    // R10, R11: only single steps, clear or ceiling reload.
    p_single_move_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_wr |=> (cnt == $past(cnt) || cnt == CW'($past(cnt) + CW'(1)) ||
                     cnt == CW'($past(cnt) - CW'(1)) || cnt == '0 ||
                     cnt == $past(ceil)));
endmodule

bind qpc_counter qpc_counter_chk #(.CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt       (cnt_q),
    .ceil      (ceil_q),
    .mode      (mode_q),
    .en        (en_q),
    .cnt_wr    (cnt_wr),
    .cnt_wdata (reg_wdata)
);

// File: tb/test_qpc_counter.sv
module test_qpc_counter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        phase_a = 1'b0;
    logic        phase_b = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    qpc_counter i_qpc_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase_a   (phase_a),
        .phase_b   (phase_b),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] addr, output logic [15:0] v);
        reg_addr = addr;
        #1;
        v = reg_rdata;
    endtask

    task automatic rd_chk(input string req, input logic [1:0] addr, input logic [15:0] exp);
        logic [15:0] v;
        rd(addr, v);
        check(req, v, exp);
    endtask

    task automatic wr(input logic [1:0] addr, input logic [15:0] data);
        reg_wr = 1'b1;
        reg_addr = addr;
        reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic pins(input logic a, input logic b);
        phase_a = a;
        phase_b = b;
        repeat (3) @(negedge clk);
    endtask

    task automatic step_chk(input string req, input logic a, input logic b, input logic [15:0] exp);
        pins(a, b);
        rd_chk(req, 2'd0, exp);
    endtask

    task automatic t_reset;
        rd_chk("R1 count", 2'd0, 16'h0000);
        rd_chk("R1 ceiling", 2'd1, 16'hFFFF);
        rd_chk("R1 control", 2'd2, 16'h0004);
        rd_chk("R1 status", 2'd3, 16'h0000);
    endtask

    task automatic t_latency;
        wr(2'd2, 16'h0104);
        rd_chk("R2 control readback", 2'd2, 16'h0104);
        phase_a = 1'b1;
        @(negedge clk);
        rd_chk("R3 after one edge", 2'd0, 16'h0000);
        @(negedge clk);
        rd_chk("R3 after two edges", 2'd0, 16'h0000);
        @(negedge clk);
        rd_chk("R3 after three edges", 2'd0, 16'h0001);
    endtask

    task automatic t_quad4;
        step_chk("R4 up 10-11", 1, 1, 16'h0002);
        step_chk("R4 up 11-01", 0, 1, 16'h0003);
        step_chk("R4 up 01-00", 0, 0, 16'h0004);
        rd_chk("R9 status up", 2'd3, 16'h0080);
        step_chk("R4 down 00-01", 0, 1, 16'h0003);
        rd_chk("R9 status down", 2'd3, 16'h0000);
        step_chk("R4 down 01-11", 1, 1, 16'h0002);
        step_chk("R4 down 11-10", 1, 0, 16'h0001);
        step_chk("R4 down 10-00", 0, 0, 16'h0000);
        step_chk("R11 down from zero to default ceiling", 0, 1, 16'hFFFF);
        step_chk("R10 up from default ceiling", 0, 0, 16'h0000);
        wr(2'd3, 16'h0000);
        rd_chk("R2 status write ignored", 2'd3, 16'h0080);
    endtask

    task automatic t_invalid;
        step_chk("R5 both change 00-11", 1, 1, 16'h0000);
        step_chk("R5 both change 11-00", 0, 0, 16'h0000);
    endtask

    task automatic t_pulse;
        wr(2'd2, 16'h0105);
        step_chk("R6 B change no count", 0, 1, 16'h0000);
        step_chk("R6 A rise B high up", 1, 1, 16'h0001);
        rd_chk("R9 pulse up status", 2'd3, 16'h0080);
        step_chk("R6 A fall no count", 0, 1, 16'h0001);
        step_chk("R6 B fall no count", 0, 0, 16'h0001);
        step_chk("R6 A rise B low down", 1, 0, 16'h0000);
        rd_chk("R9 pulse down status", 2'd3, 16'h0000);
    endtask

    task automatic t_x2b;
        wr(2'd2, 16'h0107);
        step_chk("R7 B rise A high up", 1, 1, 16'h0001);
        step_chk("R7 A change no count", 0, 1, 16'h0001);
        step_chk("R7 B fall A low up", 0, 0, 16'h0002);
        step_chk("R7 B rise A low down", 0, 1, 16'h0001);
        step_chk("R7 B fall A low up again", 0, 0, 16'h0002);
    endtask

    task automatic t_unsup;
        logic [15:0] codes [3] = '{16'h0106, 16'h0109, 16'h0100};
        foreach (codes[i]) begin
            wr(2'd2, codes[i]);
            pins(1, 0);
            pins(1, 1);
            pins(0, 1);
            step_chk("R8 unsupported mode holds", 0, 0, 16'h0002);
        end
    endtask

    task automatic t_ceiling;
        wr(2'd2, 16'h0104);
        wr(2'd1, 16'h0005);
        wr(2'd0, 16'h0004);
        rd_chk("R2 ceiling readback", 2'd1, 16'h0005);
        step_chk("R10 up to ceiling", 1, 0, 16'h0005);
        step_chk("R10 up from ceiling clears", 1, 1, 16'h0000);
        step_chk("R11 down from zero reloads ceiling", 1, 0, 16'h0005);
        step_chk("R11 down below ceiling", 0, 0, 16'h0004);
    endtask

    task automatic t_write_prio;
        phase_a = 1'b1;
        repeat (2) @(negedge clk);
        wr(2'd0, 16'h1234);
        rd_chk("R12 write wins over step", 2'd0, 16'h1234);
        @(negedge clk);
        rd_chk("R12 value held after", 2'd0, 16'h1234);
    endtask

    task automatic t_enable;
        wr(2'd2, 16'h0004);
        step_chk("R13 disabled 10-11", 1, 1, 16'h1234);
        step_chk("R13 disabled 11-01", 0, 1, 16'h1234);
        wr(2'd2, 16'h0104);
        repeat (3) @(negedge clk);
        rd_chk("R13 no spurious count on enable", 2'd0, 16'h1234);
        step_chk("R13 counts after enable", 0, 0, 16'h1235);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_latency();
        t_quad4();
        t_invalid();
        t_pulse();
        t_x2b();
        t_unsup();
        t_ceiling();
        t_write_prio();
        t_enable();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule